// File: doc/BRIEF.md
# I2C Pointer-Addressed Register Target

This block is the serial front end of a small data-converter style peripheral. It watches an I2C bus whose clock and data lines are both driven by an external controller. It recognises START and STOP conditions and answers to one fixed 7-bit address. Behind that address sit four 16-bit registers, and an internal pointer selects which one is accessed.

Register 0 is read-only. It shows the conversion result presented on `conv_data_i`. Registers 1 to 3 are writable and are exposed in parallel on `regs_o`.

A write transaction always sends the pointer first. It may then send one 16-bit value, most significant byte first. A read transaction returns the register the pointer currently selects and never carries a pointer of its own. The pointer is therefore kept between transactions.

The block drives SDA only as an open-drain pull-down, through `sda_oe_o`. It has no connection through which it could drive SCL.

Top module: `i2c_ptr_regslave`

## Requirements
- R1: An address byte whose upper seven bits differ from 1001000 is not acknowledged: SDA stays released in the ninth clock and for the rest of the transaction, until the next START.
- R2: An address byte whose upper seven bits are 1001000 (0x48) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 is write, 1 is read.
- R3: In a write, the first byte after the address loads the pointer. Its two low bits select the register: 0 is the conversion result, 1 is configuration, 2 and 3 are general registers. A write that stops after the pointer byte changes no register.
- R4: The second and third bytes of a write form the most significant and least significant byte of a value. That value is stored in the register the pointer selects. Every byte written is acknowledged. `regs_o` places register 1 in bits 15:0, register 2 in bits 31:16 and register 3 in bits 47:32.
- R5: Data written while the pointer is 0 is acknowledged but discarded. Later reads of register 0 still return `conv_data_i`.
- R6: A read returns the selected register, most significant byte first and then least significant byte, each byte MSB first. The data changes only after SCL falling edges. Register 0 returns the value of `conv_data_i` captured when the read starts.
- R7: The pointer keeps its value from one transaction to the next. Reset sets it to 0.
- R8: When the controller answers a read byte with NACK, the block releases SDA and keeps it released until the next START.
- R9: A START seen in the middle of a byte, including a repeated START, discards that partial byte. The block then returns to matching the address, and the pointer is left unchanged.
- R10: SDA is released after reset and after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| conv_data_i | input | 16 | Conversion result shown as register 0 |
| regs_o | output | 48 | Registers 3, 2, 1 concatenated, register 1 lowest |

## Verification
The bench sends a foreign address to show that matching selects on the address bits alone, and both directions of the right address to show that the R/W bit steers the transfer. Full writes to pointers 1, 2 and 3 are compared with writes that carry only a pointer and with writes to pointer 0. This separates the pointer path, the data path and the read-only register. Reads that reuse a pointer from an earlier transaction or from before a reset, a read cut short by a NACK, and a write broken off mid-byte by a repeated START each target one rule about keeping or dropping state.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in the address byte
        ST_ACK_ADDR,  // holding ACK for the address
        ST_WR,        // shifting in a written byte
        ST_ACK_WR,    // holding ACK for a written byte
        ST_RD,        // shifting out a read byte
        ST_RD_ACK     // sampling the controller's ACK/NACK
    } proto_st_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    logic scl_s;

    always_comb begin
        d        = q;
        d.scl_sh = (q.scl_sh << 1) | STAGES'(scl_i);
        d.sda_sh = (q.sda_sh << 1) | STAGES'(sda_i);
        d.scl_p  = q.scl_sh[STAGES-1];
        d.sda_p  = q.sda_sh[STAGES-1];
    end

    // idle bus is high, so reset to ones to avoid false edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_sh[STAGES-1];
    assign sda_s     = q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int DATA_W = 16,
    parameter int NREG   = 4,
    localparam int PTR_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [PTR_W-1:0]           wsel,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W-1:0]          conv_i,
    input  logic [PTR_W-1:0]           rsel,
    output logic [DATA_W-1:0]          rdata,
    output logic [(NREG-1)*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] bank_d [NREG-1];
    logic [DATA_W-1:0] bank_q [NREG-1];

    // index 0 is the read-only result; only 1..NREG-1 are stored
    for (genvar i = 1; i < NREG; i++) begin : g_reg
        always_comb begin
            bank_d[i-1] = bank_q[i-1];
            if (we && wsel == PTR_W'(i)) bank_d[i-1] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[i-1] <= '0;
            else        bank_q[i-1] <= bank_d[i-1];
        end

        assign regs_o[(i-1)*DATA_W +: DATA_W] = bank_q[i-1];
    end

    always_comb begin
        rdata = conv_i;
        for (int k = 1; k < NREG; k++) begin
            if (rsel == PTR_W'(k)) rdata = bank_q[k-1];
        end
    end

endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_ptr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         DATA_W   = 16,   // two bytes per register
    parameter int         NREG     = 4,
    localparam int        PTR_W    = $clog2(NREG),
    localparam int        BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rdata,
    output logic              sda_oe,
    output logic              we,
    output logic [PTR_W-1:0]  wsel,
    output logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr
);

    typedef struct packed {
        proto_st_e         state;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shreg;
        logic              oe;
        logic              rw;
        logic [PTR_W-1:0]  ptr;
        logic [1:0]        widx;
        logic [BYTE_W-1:0] msb;
        logic [DATA_W-1:0] rword;
        logic              ridx;
        logic              mack;
        logic              we;
        logic [PTR_W-1:0]  wsel;
        logic [DATA_W-1:0] wdata;
    } fsm_t;

    fsm_t q, d;

    logic [BYTE_W-1:0] next_rd_byte;

    // byte offered after a controller ACK: LSB after MSB, then wrap
    assign next_rd_byte = q.ridx ? q.rword[DATA_W-1 -: BYTE_W] : q.rword[BYTE_W-1:0];

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (start_det) begin
            d.state = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.widx  = '0;
            d.ridx  = 1'b0;
        end else begin
            case (q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                            d.state = ST_ACK_ADDR;
                            d.oe    = 1'b1;
                            d.rw    = q.shreg[0];
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.state = ST_RD;
                            d.rword = rdata;
                            d.shreg = rdata[DATA_W-1 -: BYTE_W];
                            d.oe    = ~rdata[DATA_W-1];
                            d.ridx  = 1'b0;
                        end else begin
                            d.state = ST_WR;
                            d.oe    = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.state = ST_ACK_WR;
                        d.oe    = 1'b1;
                        case (q.widx)
                            2'd0: d.ptr = q.shreg[PTR_W-1:0];
                            2'd1: d.msb = q.shreg;
                            2'd2: begin
                                d.we    = 1'b1;
                                d.wsel  = q.ptr;
                                d.wdata = {q.msb, q.shreg};
                            end
                            default: ;
                        endcase
                        if (q.widx != 2'd3) d.widx = q.widx + 2'd1;
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        d.state = ST_WR;
                        d.oe    = 1'b0;
                        d.cnt   = '0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.state = ST_RD_ACK;
                            d.oe    = 1'b0;
                            d.mack  = 1'b0;
                        end else begin
                            d.shreg = q.shreg << 1;
                            d.oe    = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.state = ST_RD;
                            d.ridx  = ~q.ridx;
                            d.shreg = next_rd_byte;
                            d.oe    = ~next_rd_byte[BYTE_W-1];
                            d.cnt   = '0;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign we     = q.we;
    assign wsel   = q.wsel;
    assign wdata  = q.wdata;
    assign ptr    = q.ptr;

endmodule

// File: rtl/i2c_ptr_regslave.sv
module i2c_ptr_regslave #(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         DATA_W      = 16,
    parameter int         NREG        = 4,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(NREG),
    localparam int        REGS_W      = (NREG-1)*DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic [REGS_W-1:0] regs_o
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              reg_we;
    logic [PTR_W-1:0]  reg_wsel;
    logic [DATA_W-1:0] reg_wdata;
    logic [PTR_W-1:0]  reg_ptr;
    logic [DATA_W-1:0] reg_rdata;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_proto_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .DATA_W   (DATA_W),
        .NREG     (NREG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (reg_rdata),
        .sda_oe    (sda_oe_o),
        .we        (reg_we),
        .wsel      (reg_wsel),
        .wdata     (reg_wdata),
        .ptr       (reg_ptr)
    );

    i2c_reg_bank #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wsel   (reg_wsel),
        .wdata  (reg_wdata),
        .conv_i (conv_data_i),
        .rsel   (reg_ptr),
        .rdata  (reg_rdata),
        .regs_o (regs_o)
    );

endmodule

// File: rtl/i2c_ptr_regslave_chk.sv
module i2c_ptr_regslave_chk #(
    parameter int RW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_fall,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_oe_o,
    input logic          reg_we,
    input logic [RW-1:0] regs_o
);

    // SDA only moves after an SCL fall, START or STOP
    assert_sda_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe_o);

    assert_release_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> !sda_oe_o);

    assert_write_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(scl_fall));

    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> $stable(regs_o));

endmodule

bind i2c_ptr_regslave i2c_ptr_regslave_chk #(
    .RW ((NREG-1)*DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe_o  (sda_oe_o),
    .reg_we    (reg_we),
    .regs_o    (regs_o)
);

// File: tb/i2c_ptr_regslave_bench.sv
module i2c_ptr_regslave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;    // clk cycles per quarter SCL period
    localparam logic [7:0] ADR_W = 8'h90;
    localparam logic [7:0] ADR_R = 8'h91;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_line;
    logic        oe;
    logic [15:0] conv = 16'h1234;
    logic [47:0] regs;

    assign sda_line = ~(m_low | oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ptr_regslave u_i2c_ptr_regslave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (oe),
        .conv_data_i (conv),
        .regs_o      (regs)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];

    task automatic check(input bit ok, input string req,
                         input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pairs each received byte with its expectation
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                exp_t       e;
                logic [7:0] g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                check(g == e.val, e.req, {40'h0, g}, {40'h0, e.val});
            end
        end
    end

    task automatic qwait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; qwait();
        scl   = 1'b1; qwait();
        m_low = 1'b1; qwait();
        scl   = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait();
        scl   = 1'b1; qwait();
        m_low = 1'b0; qwait();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_low = ~b; qwait();
        scl   = 1'b1; qwait();
        s     = sda_line; qwait();
        scl   = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack   = ~s;
        m_low = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, input logic [7:0] expv, input string req);
        logic       s;
        logic [7:0] v;
        exp_q.push_back('{val: expv, req: req});
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        got_q.push_back(v);
        clk_bit(~give_ack, s);
        m_low = 1'b0;
    endtask

    // full write: pointer, optional 16-bit value; all acks expected
    task automatic write_txn(input logic [7:0] p, input bit with_data,
                             input logic [15:0] val, input string req);
        logic ack;
        bus_start();
        send_byte(ADR_W, ack);
        check(ack, "R2", {47'h0, ack}, 48'h1);
        send_byte(p, ack);
        check(ack, req, {47'h0, ack}, 48'h1);
        if (with_data) begin
            send_byte(val[15:8], ack);
            check(ack, req, {47'h0, ack}, 48'h1);
            send_byte(val[7:0], ack);
            check(ack, req, {47'h0, ack}, 48'h1);
        end
        bus_stop();
    endtask

    task automatic read_txn(input logic [15:0] expv, input string req);
        logic ack;
        bus_start();
        send_byte(ADR_R, ack);
        check(ack, "R2", {47'h0, ack}, 48'h1);
        recv_byte(1'b1, expv[15:8], req);
        recv_byte(1'b0, expv[7:0], req);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic s;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: released after reset; R7: registers cleared
        check(oe == 1'b0, "R10", {47'h0, oe}, 48'h0);
        check(regs == 48'h0, "R7", regs, 48'h0);

        // R1: foreign address gets no ACK
        bus_start();
        send_byte(8'hA0, ack);
        check(!ack, "R1", {47'h0, ack}, 48'h0);
        send_byte(8'h01, ack);
        check(!ack, "R1", {47'h0, ack}, 48'h0);
        bus_stop();
        check(oe == 1'b0, "R10", {47'h0, oe}, 48'h0);

        // R4: full write to configuration register
        write_txn(8'h01, 1'b1, 16'h8483, "R4");
        check(regs == 48'h0000_0000_8483, "R4", regs, 48'h0000_0000_8483);

        // R6 R7: read reuses the sticky pointer (config)
        read_txn(16'h8483, "R6");

        // R8: after NACK further clocks see a released line
        bus_start();
        send_byte(ADR_R, ack);
        check(ack, "R2", {47'h0, ack}, 48'h1);
        recv_byte(1'b1, 8'h84, "R6");
        recv_byte(1'b0, 8'h83, "R6");
        recv_byte(1'b0, 8'hFF, "R8");
        bus_stop();

        // R3: pointer-only write moves the pointer, leaves registers
        write_txn(8'h00, 1'b0, 16'h0, "R3");
        check(regs == 48'h0000_0000_8483, "R3", regs, 48'h0000_0000_8483);
        read_txn(16'h1234, "R6");

        // R5: write to conversion register is acked and dropped
        write_txn(8'h00, 1'b1, 16'hAA55, "R5");
        check(regs == 48'h0000_0000_8483, "R5", regs, 48'h0000_0000_8483);
        conv = 16'hC3A5;
        read_txn(16'hC3A5, "R5");

        // R4: registers 3 and 2
        write_txn(8'h03, 1'b1, 16'hBEEF, "R4");
        write_txn(8'h02, 1'b1, 16'h0102, "R4");
        check(regs == 48'hBEEF_0102_8483, "R4", regs, 48'hBEEF_0102_8483);
        read_txn(16'h0102, "R7");

        // R9: set pointer to 1, then abort a pointer byte with repeated START
        write_txn(8'h01, 1'b0, 16'h0, "R3");
        bus_start();
        send_byte(ADR_W, ack);
        check(ack, "R2", {47'h0, ack}, 48'h1);
        clk_bit(1'b0, s);
        clk_bit(1'b0, s);
        clk_bit(1'b0, s);
        bus_start();
        send_byte(ADR_R, ack);
        check(ack, "R9", {47'h0, ack}, 48'h1);
        recv_byte(1'b1, 8'h84, "R9");
        recv_byte(1'b0, 8'h83, "R9");
        bus_stop();

        // R7: reset returns pointer to 0 and clears registers
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(regs == 48'h0, "R7", regs, 48'h0);
        read_txn(16'hC3A5, "R7");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6", 48'(exp_q.size()), 48'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule